// File: doc/BRIEF.md
# Register Field Validator and Mapper

This block sits in an instruction decode path. It takes a 5-bit register field pulled from an instruction word and a code that names the operand's register class. It decides whether the field is a legal choice for that class. When it is legal, the block also gives the architectural register number the field stands for. Some classes pass the field through unchanged, some move it to a new base, and some use a lookup.

Two configuration inputs shape the checks. The first says that only the lower half of the integer register file exists. The second gives the vector grouping factor as a power of two. A parameter adds one register stage on the result, so the result appears one clock after its inputs. When the block rejects a field, every result output reads zero. A separate flag marks the one legal case that names no register: the mask operand that means "no mask".

Top module: `regfield_mapper`

## Requirements
- R1: Class 0 (plain integer) accepts every field value and returns the field as the index. When `reduced_i` is high, a field of 16 or more is rejected.
- R2: Class 1 rejects field 0, class 2 rejects field 2 and class 3 rejects field 31. Any other value follows the R1 rules, including the reduced-file limit.
- R3: Class 4 (link register) accepts only fields 1 and 5 and returns them unchanged. It rejects every other value.
- R4: Class 5 (register pair) accepts any even field and returns it unchanged. Class 6 (compressed pair) accepts only even fields below 8 and returns the field plus 8.
- R5: Class 7 (compressed saved register) accepts fields 0 to 7. Fields 0 and 1 map to registers 8 and 9, and fields 2 to 7 map to registers 18 to 23. Fields of 8 or more are rejected.
- R6: Class 8 (vector group) accepts a field only when it is a multiple of 2^`vlmul_i` (1, 2, 4 or 8), and returns the field unchanged.
- R7: Class 9 (two-tile group) accepts even fields up to 15. Class 10 (four-tile group) accepts multiples of 4 up to 15. Both return the field unchanged.
- R8: Class 11 (vector mask) accepts fields 0 and 1 and returns index 0. `nomask_o` is low for field 0 (vector register 0) and high for field 1 (no mask). Fields of 2 or more are rejected.
- R9: Class codes 12 to 15 are always rejected. Whenever `valid_o` is low, `index_o` and `nomask_o` are both 0.
- R10: With the default output stage, the result of the inputs present at a rising clock edge appears after that edge. A synchronous `rst` clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst | input | 1 | Synchronous active-high reset |
| field_i | input | 5 | Register field taken from the instruction |
| cls_i | input | 4 | Register class code (0 to 11 defined) |
| reduced_i | input | 1 | Only the 16-entry integer register file exists |
| vlmul_i | input | 2 | Base-2 log of the vector grouping factor |
| valid_o | output | 1 | The field is legal for the class |
| index_o | output | 5 | Architectural register number, 0 when invalid |
| nomask_o | output | 1 | A legal mask operand that names no register |

## Verification
The clocked properties assume that every input is a known value at each rising edge. They also assume that inputs change only between edges, so that the value a property samples is the value the output stage captured. The stimulus drives every input on the falling edge and holds it for a full cycle. It uses class codes from both the defined and the undefined ranges, and it changes `reduced_i` and `vlmul_i` only together with the other inputs. As a result, a property's antecedent and the result that follows it always belong to the same vector.

// File: rtl/regmap_pkg.sv
package regmap_pkg;

    localparam int FIELD_W      = 5;
    localparam int CLS_W        = 4;
    localparam int LMUL_W       = 2;
    localparam int REDUCED_TOP  = 16;
    localparam int CPAIR_SPAN   = 8;
    localparam int CPAIR_BASE   = 8;
    localparam int SAVED_SPAN   = 8;
    localparam int SAVED_LO_BAS = 8;
    localparam int SAVED_HI_BAS = 18;
    localparam int SAVED_SPLIT  = 2;
    localparam int TILE_TOP     = 15;
    localparam int LINK_A       = 1;
    localparam int LINK_B       = 5;

    typedef enum logic [CLS_W-1:0] {
        RC_INT      = 4'd0,
        RC_INT_NZ0  = 4'd1,
        RC_INT_NZ2  = 4'd2,
        RC_INT_NZ31 = 4'd3,
        RC_LINK     = 4'd4,
        RC_PAIR     = 4'd5,
        RC_PAIR_C   = 4'd6,
        RC_SAVED    = 4'd7,
        RC_VGRP     = 4'd8,
        RC_TILE2    = 4'd9,
        RC_TILE4    = 4'd10,
        RC_VMASK    = 4'd11
    } rclass_e;

    typedef struct packed {
        logic               ok;
        logic [FIELD_W-1:0] idx;
        logic               none;
    } rmap_t;

    localparam rmap_t RMAP_NULL = '{ok: 1'b0, idx: '0, none: 1'b0};

    // True when the low 'lg' bits of 'v' are all zero.
    function automatic logic is_aligned(input logic [FIELD_W-1:0] v,
                                        input logic [LMUL_W-1:0]  lg);
        logic [FIELD_W-1:0] m;
        m = FIELD_W'((1 << lg) - 1);
        return (v & m) == '0;
    endfunction

    function automatic rmap_t pass(input logic ok_in, input logic [FIELD_W-1:0] v);
        rmap_t r;
        r      = RMAP_NULL;
        r.ok   = ok_in;
        r.idx  = v;
        return r;
    endfunction

endpackage

// File: rtl/regmap_scalar.sv
module regmap_scalar
    import regmap_pkg::*;
(
    input  logic [FIELD_W-1:0] field_i,
    input  rclass_e            cls_i,
    input  logic               reduced_i,
    output logic               hit_o,
    output rmap_t              map_o
);
    logic int_ok;

    always_comb begin
        int_ok = !(reduced_i && (32'(field_i) >= REDUCED_TOP));
        hit_o  = 1'b1;
        map_o  = RMAP_NULL;
        unique case (cls_i)
            RC_INT:      map_o = pass(int_ok, field_i);
            RC_INT_NZ0:  map_o = pass(int_ok && field_i != 5'd0, field_i);
            RC_INT_NZ2:  map_o = pass(int_ok && field_i != 5'd2, field_i);
            RC_INT_NZ31: map_o = pass(int_ok && field_i != 5'd31, field_i);
            RC_LINK:     map_o = pass(32'(field_i) == LINK_A || 32'(field_i) == LINK_B,
                                      field_i);
            RC_SAVED: begin
                map_o.ok = 32'(field_i) < SAVED_SPAN;
                if (32'(field_i) < SAVED_SPLIT)
                    map_o.idx = FIELD_W'(SAVED_LO_BAS) + field_i;
                else
                    map_o.idx = FIELD_W'(SAVED_HI_BAS - SAVED_SPLIT) + field_i;
            end
            default:     hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/regmap_group.sv
module regmap_group
    import regmap_pkg::*;
(
    input  logic [FIELD_W-1:0] field_i,
    input  rclass_e            cls_i,
    input  logic [LMUL_W-1:0]  vlmul_i,
    output logic               hit_o,
    output rmap_t              map_o
);
    logic tile_in;

    always_comb begin
        tile_in = 32'(field_i) <= TILE_TOP;
        hit_o   = 1'b1;
        map_o   = RMAP_NULL;
        unique case (cls_i)
            RC_PAIR:   map_o = pass(is_aligned(field_i, 2'd1), field_i);
            RC_PAIR_C: map_o = pass(is_aligned(field_i, 2'd1) &&
                                    32'(field_i) < CPAIR_SPAN,
                                    field_i + FIELD_W'(CPAIR_BASE));
            RC_VGRP:   map_o = pass(is_aligned(field_i, vlmul_i), field_i);
            RC_TILE2:  map_o = pass(tile_in && is_aligned(field_i, 2'd1), field_i);
            RC_TILE4:  map_o = pass(tile_in && is_aligned(field_i, 2'd2), field_i);
            RC_VMASK: begin
                map_o.ok   = field_i[FIELD_W-1:1] == '0;
                map_o.idx  = '0;
                map_o.none = field_i[0];
            end
            default:   hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/regfield_mapper.sv
module regfield_mapper
    import regmap_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [FIELD_W-1:0] field_i,
    input  logic [CLS_W-1:0]   cls_i,
    input  logic               reduced_i,
    input  logic [LMUL_W-1:0]  vlmul_i,
    output logic               valid_o,
    output logic [FIELD_W-1:0] index_o,
    output logic               nomask_o
);
    rclass_e cls_e;
    logic    sc_hit, gr_hit;
    rmap_t   sc_map, gr_map, sel, res_q;

    assign cls_e = rclass_e'(cls_i);

    regmap_scalar u_scalar (
        .field_i   (field_i),
        .cls_i     (cls_e),
        .reduced_i (reduced_i),
        .hit_o     (sc_hit),
        .map_o     (sc_map)
    );

    regmap_group u_group (
        .field_i (field_i),
        .cls_i   (cls_e),
        .vlmul_i (vlmul_i),
        .hit_o   (gr_hit),
        .map_o   (gr_map)
    );

    // Pick the owning sub-decoder, then zero everything on a reject.
    always_comb begin
        sel = RMAP_NULL;
        if (sc_hit && sc_map.ok)
            sel = sc_map;
        else if (gr_hit && gr_map.ok)
            sel = gr_map;
    end

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) res_q <= RMAP_NULL;
                else     res_q <= sel;
            end

            // R1
            r1_reduced_chk: assert property (@(posedge clk) disable iff (rst)
                (cls_i == 4'd0 && reduced_i && field_i[4]) |=> !valid_o);
            // R3
            r3_link_chk: assert property (@(posedge clk) disable iff (rst)
                (cls_i == 4'd4) |=> (!valid_o || index_o == 5'd1 || index_o == 5'd5));
            // R4
            r4_cpair_chk: assert property (@(posedge clk) disable iff (rst)
                (cls_i == 4'd6) |=> (!valid_o || (index_o >= 5'd8 && index_o <= 5'd14
                                                  && !index_o[0])));
            // R6
            r6_align_chk: assert property (@(posedge clk) disable iff (rst)
                (cls_i == 4'd8 && vlmul_i == 2'd3) |=> (!valid_o || index_o[2:0] == 3'd0));
            // R9
            r9_unknown_chk: assert property (@(posedge clk) disable iff (rst)
                (cls_i >= 4'd12) |=> (!valid_o && index_o == '0 && !nomask_o));
        end else begin : g_comb
            assign res_q = sel;
        end
    endgenerate

    assign valid_o  = res_q.ok;
    assign index_o  = res_q.idx;
    assign nomask_o = res_q.none;

endmodule

// File: tb/sim_regfield_mapper.sv
module sim_regfield_mapper;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] field_i = '0;
    logic [3:0] cls_i = '0;
    logic       reduced_i = 1'b0;
    logic [1:0] vlmul_i = '0;
    logic       valid_o, nomask_o;
    logic [4:0] index_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    regfield_mapper u0 (
        .clk       (clk),
        .rst       (rst),
        .field_i   (field_i),
        .cls_i     (cls_i),
        .reduced_i (reduced_i),
        .vlmul_i   (vlmul_i),
        .valid_o   (valid_o),
        .index_o   (index_o),
        .nomask_o  (nomask_o)
    );

    // {req, cls, field, reduced, vlmul, exp_valid, exp_index, exp_nomask}
    localparam int NV = 42;
    localparam logic [22:0] TBL [NV] = '{
        {4'd1, 4'd0,  5'd0,  1'b0, 2'd0, 1'b1, 5'd0,  1'b0},  // R1
        {4'd1, 4'd0,  5'd31, 1'b0, 2'd0, 1'b1, 5'd31, 1'b0},  // R1
        {4'd1, 4'd0,  5'd15, 1'b1, 2'd0, 1'b1, 5'd15, 1'b0},  // R1
        {4'd1, 4'd0,  5'd16, 1'b1, 2'd0, 1'b0, 5'd0,  1'b0},  // R1
        {4'd2, 4'd1,  5'd0,  1'b0, 2'd0, 1'b0, 5'd0,  1'b0},  // R2
        {4'd2, 4'd1,  5'd1,  1'b0, 2'd0, 1'b1, 5'd1,  1'b0},  // R2
        {4'd2, 4'd2,  5'd2,  1'b0, 2'd0, 1'b0, 5'd0,  1'b0},  // R2
        {4'd2, 4'd2,  5'd3,  1'b0, 2'd0, 1'b1, 5'd3,  1'b0},  // R2
        {4'd2, 4'd3,  5'd31, 1'b0, 2'd0, 1'b0, 5'd0,  1'b0},  // R2
        {4'd2, 4'd3,  5'd30, 1'b0, 2'd0, 1'b1, 5'd30, 1'b0},  // R2
        {4'd2, 4'd3,  5'd20, 1'b1, 2'd0, 1'b0, 5'd0,  1'b0},  // R2
        {4'd3, 4'd4,  5'd1,  1'b0, 2'd0, 1'b1, 5'd1,  1'b0},  // R3
        {4'd3, 4'd4,  5'd5,  1'b0, 2'd0, 1'b1, 5'd5,  1'b0},  // R3
        {4'd3, 4'd4,  5'd2,  1'b0, 2'd0, 1'b0, 5'd0,  1'b0},  // R3
        {4'd3, 4'd4,  5'd0,  1'b0, 2'd0, 1'b0, 5'd0,  1'b0},  // R3
        {4'd4, 4'd5,  5'd6,  1'b0, 2'd0, 1'b1, 5'd6,  1'b0},  // R4
        {4'd4, 4'd5,  5'd7,  1'b0, 2'd0, 1'b0, 5'd0,  1'b0},  // R4
        {4'd4, 4'd5,  5'd30, 1'b0, 2'd0, 1'b1, 5'd30, 1'b0},  // R4
        {4'd4, 4'd6,  5'd0,  1'b0, 2'd0, 1'b1, 5'd8,  1'b0},  // R4
        {4'd4, 4'd6,  5'd6,  1'b0, 2'd0, 1'b1, 5'd14, 1'b0},  // R4
        {4'd4, 4'd6,  5'd8,  1'b0, 2'd0, 1'b0, 5'd0,  1'b0},  // R4
        {4'd4, 4'd6,  5'd3,  1'b0, 2'd0, 1'b0, 5'd0,  1'b0},  // R4
        {4'd5, 4'd7,  5'd0,  1'b0, 2'd0, 1'b1, 5'd8,  1'b0},  // R5
        {4'd5, 4'd7,  5'd1,  1'b0, 2'd0, 1'b1, 5'd9,  1'b0},  // R5
        {4'd5, 4'd7,  5'd2,  1'b0, 2'd0, 1'b1, 5'd18, 1'b0},  // R5
        {4'd5, 4'd7,  5'd7,  1'b0, 2'd0, 1'b1, 5'd23, 1'b0},  // R5
        {4'd5, 4'd7,  5'd8,  1'b0, 2'd0, 1'b0, 5'd0,  1'b0},  // R5
        {4'd6, 4'd8,  5'd5,  1'b0, 2'd0, 1'b1, 5'd5,  1'b0},  // R6
        {4'd6, 4'd8,  5'd6,  1'b0, 2'd1, 1'b1, 5'd6,  1'b0},  // R6
        {4'd6, 4'd8,  5'd6,  1'b0, 2'd2, 1'b0, 5'd0,  1'b0},  // R6
        {4'd6, 4'd8,  5'd24, 1'b0, 2'd3, 1'b1, 5'd24, 1'b0},  // R6
        {4'd6, 4'd8,  5'd12, 1'b0, 2'd3, 1'b0, 5'd0,  1'b0},  // R6
        {4'd7, 4'd9,  5'd14, 1'b0, 2'd0, 1'b1, 5'd14, 1'b0},  // R7
        {4'd7, 4'd9,  5'd16, 1'b0, 2'd0, 1'b0, 5'd0,  1'b0},  // R7
        {4'd7, 4'd9,  5'd3,  1'b0, 2'd0, 1'b0, 5'd0,  1'b0},  // R7
        {4'd7, 4'd10, 5'd12, 1'b0, 2'd0, 1'b1, 5'd12, 1'b0},  // R7
        {4'd7, 4'd10, 5'd6,  1'b0, 2'd0, 1'b0, 5'd0,  1'b0},  // R7
        {4'd8, 4'd11, 5'd0,  1'b0, 2'd0, 1'b1, 5'd0,  1'b0},  // R8
        {4'd8, 4'd11, 5'd1,  1'b0, 2'd0, 1'b1, 5'd0,  1'b1},  // R8
        {4'd8, 4'd11, 5'd2,  1'b0, 2'd0, 1'b0, 5'd0,  1'b0},  // R8
        {4'd9, 4'd12, 5'd3,  1'b0, 2'd0, 1'b0, 5'd0,  1'b0},  // R9
        {4'd9, 4'd15, 5'd0,  1'b0, 2'd0, 1'b0, 5'd0,  1'b0}   // R9
    };

    task automatic check(input int req, input logic v, input logic [4:0] ix, input logic nm);
        n_chk++;
        if (valid_o !== v || index_o !== ix || nomask_o !== nm) begin
            n_bad++;
            $display("FAIL R%0d: got valid=%b index=%0d nomask=%b, expected valid=%b index=%0d nomask=%b",
                     req, valid_o, index_o, nomask_o, v, ix, nm);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(10, 1'b0, 5'd0, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cls_i     = TBL[i][18:15];
            field_i   = TBL[i][14:10];
            reduced_i = TBL[i][9];
            vlmul_i   = TBL[i][8:7];
            @(negedge clk);
            check(int'(TBL[i][22:19]), TBL[i][6], TBL[i][5:1], TBL[i][0]);
        end

        // R10: result waits for the edge; inputs changed mid-cycle do not show yet
        @(negedge clk);
        cls_i = 4'd7; field_i = 5'd7; reduced_i = 1'b0; vlmul_i = 2'd0;
        @(negedge clk);
        cls_i = 4'd4; field_i = 5'd5;
        #1;
        check(10, 1'b1, 5'd23, 1'b0);
        @(negedge clk);
        check(10, 1'b1, 5'd5, 1'b0);

        // R10: synchronous reset clears a valid result
        rst = 1'b1;
        @(negedge clk);
        check(10, 1'b0, 5'd0, 1'b0);
        rst = 1'b0;

        // R1: reduced file upper edge with the full file allowed
        cls_i = 4'd0; field_i = 5'd16; reduced_i = 1'b0;
        @(negedge clk);
        check(1, 1'b1, 5'd16, 1'b0);

        // R9: a rejected mask field right after a no-mask result clears nomask
        cls_i = 4'd11; field_i = 5'd1;
        @(negedge clk);
        check(8, 1'b1, 5'd0, 1'b1);
        field_i = 5'd3;
        @(negedge clk);
        check(9, 1'b0, 5'd0, 1'b0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL R10: watchdog expired, got no completion, expected completion");
            end
        join_any
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule